// File: doc/BRIEF.md
# Interrupt Status and Command Sequencer

This block is the status and interrupt core of a small storage host adapter's register interface. Software writes a byte into a command register. Each recognised opcode updates three read-only registers to a pattern of its own: the status register, the interrupt-reason register and the sequence-step register. A single level interrupt output always mirrors the interrupt bit of the status register. Reading the interrupt-reason register acknowledges the interrupt as a side effect.

Three opcodes start bus work: transfer, select, and select-with-attention. Bus phases and data movement live outside this block. A launched operation appears as a one-cycle `launch` pulse. Its completion comes back on the `op_done` strobe.

If the DMA flag of a launch opcode is set while `dma_en` is low, the operation is parked. It launches on the first cycle `dma_en` is seen high.

The sequencer has three states:
- `ST_IDLE`: no operation outstanding.
- `ST_WAIT_DMA`: a DMA operation is parked until DMA is enabled.
- `ST_BUSY`: an operation has launched and awaits `op_done`.

Transitions:
- From `ST_IDLE`, a launch opcode goes to `ST_BUSY`. If it is a DMA opcode and `dma_en` is low, it goes to `ST_WAIT_DMA` instead.
- `ST_WAIT_DMA` goes to `ST_BUSY` when `dma_en` is high.
- `ST_BUSY` goes to `ST_IDLE` on `op_done`.
- Any state goes to `ST_IDLE` on reset or on the soft-reset opcode.
- A launch opcode written in any state re-enters `ST_BUSY` or `ST_WAIT_DMA` by the same rule.

Top module: `ctl_irq_core`

## Requirements
- R1: Register map.
  - Reads: address 0 command, 1 status, 2 interrupt reason, 3 sequence step, 4 flags, 5 config.
  - Writes take effect only at address 0 (command) and address 5 (config).
  - Status bit 7 is INT and bit 4 is TC.
  - `irq` equals status bit 7 at all times.
  - `irq` rises only in the cycle after a register write or a completion strobe.
- R2: A read strobe at address 2 returns the old reason value on `rd_data` in that cycle. On the following edge it does four things:
  - clears the reason register;
  - clears status bits 7 and 4;
  - sets the step register to 4;
  - drops `irq`.
- R3: Opcode 0x03 (bus reset) sets the reason to 0x80. It sets INT only when config bit 6 is 0; otherwise `irq` stays unchanged.
- R4: Opcode 0x01 (flush) sets the reason to 0x08 and zeroes the step and flags registers. It leaves INT unchanged.
- R5: Opcode 0x12 (message accept) sets the reason to 0x20, zeroes step and flags, and sets INT.
- R6: Opcode 0x44 (enable selection) zeroes the reason only. Opcode 0x45 (disable selection) zeroes the reason and sets INT.
- R7: Opcode 0x18 (pad) sets status TC, sets the reason to 0x08 and zeroes step. It leaves INT unchanged.
- R8: Launch opcodes are 0x10, 0x41 and 0x42; command bit 7 is the DMA flag.
  - Without the DMA flag, or with `dma_en` high, `launch` pulses for one cycle right after the write edge.
  - With the DMA flag and `dma_en` low, no launch occurs. `launch` pulses once, on the cycle after the first edge that sees `dma_en` high.
  - `launch_op` carries the opcode and `launch_dma` carries the flag.
- R9: `op_done` in `ST_BUSY` sets status to 0x90, reason to 0x18 and step to 4, and loads flags from `done_flags`. In any other state it is ignored.
- R10: After `rst_n` low, or opcode 0x02 (soft reset), every register reads 0 except config, which reads 7. `irq` is low and the state is `ST_IDLE`.
- R11: A recognised opcode stores the whole written byte in the command register (soft reset leaves it 0). Any other opcode changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle register write strobe |
| rd_en | input | 1 | Read strobe; qualifies read side effects |
| addr | input | ADDR_W | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| dma_en | input | 1 | DMA engine enabled level |
| op_done | input | 1 | Completion strobe of the launched operation |
| done_flags | input | 8 | Flags value captured on completion |
| irq | output | 1 | Level interrupt |
| launch | output | 1 | One-cycle start pulse for bus work |
| launch_op | output | 7 | Opcode of the launched operation |
| launch_dma | output | 1 | DMA flag of the launched operation |

## Verification
The checker watches several rules on every cycle:
- the interrupt only rises after a write or a completion;
- an acknowledge read leaves the line low;
- a masked bus reset and a flush never raise the line;
- a DMA launch never appears unless DMA was enabled the cycle before;
- no launch emerges while DMA is off and no command is written.

The bench shows the full per-opcode register patterns. It sweeps all 128 opcodes against both values of the DMA flag and of `dma_en`, from a fresh reset each time.

Directed scenarios cover the rest:
- the old-value return of the reason read;
- the exact launch cycle after a parked command;
- completion flags;
- completion being ignored when nothing is outstanding;
- the config reset value.

// File: rtl/ctl_irq_pkg.sv
package ctl_irq_pkg;
    localparam int REG_W = 8;
    localparam int OP_W  = 7;

    localparam logic [OP_W-1:0] OP_NOP    = 7'h00;
    localparam logic [OP_W-1:0] OP_FLUSH  = 7'h01;
    localparam logic [OP_W-1:0] OP_SRST   = 7'h02;
    localparam logic [OP_W-1:0] OP_BRST   = 7'h03;
    localparam logic [OP_W-1:0] OP_XFER   = 7'h10;
    localparam logic [OP_W-1:0] OP_MSGACC = 7'h12;
    localparam logic [OP_W-1:0] OP_PAD    = 7'h18;
    localparam logic [OP_W-1:0] OP_SEL    = 7'h41;
    localparam logic [OP_W-1:0] OP_SELATN = 7'h42;
    localparam logic [OP_W-1:0] OP_ENSEL  = 7'h44;
    localparam logic [OP_W-1:0] OP_DISSEL = 7'h45;

    localparam int A_CMD    = 0;
    localparam int A_STAT   = 1;
    localparam int A_REASON = 2;
    localparam int A_STEP   = 3;
    localparam int A_FLAGS  = 4;
    localparam int A_CFG1   = 5;

    localparam int ST_INT    = 7;
    localparam int ST_TC     = 4;
    localparam int CFG_NOREP = 6;

    localparam logic [REG_W-1:0] RS_RESET = 8'h80;
    localparam logic [REG_W-1:0] RS_DISC  = 8'h20;
    localparam logic [REG_W-1:0] RS_BUS   = 8'h10;
    localparam logic [REG_W-1:0] RS_FC    = 8'h08;
    localparam logic [REG_W-1:0] STEP_DONE = 8'h04;
    localparam logic [REG_W-1:0] CFG1_INIT = 8'h07;

    typedef enum logic [3:0] {
        CK_NONE, CK_NOP, CK_FLUSH, CK_SRST, CK_BRST,
        CK_MSGACC, CK_PAD, CK_ENSEL, CK_DISSEL, CK_LAUNCH
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_WAIT_DMA, ST_BUSY
    } seq_state_e;
endpackage

// File: rtl/ctl_cmd_decode.sv
module ctl_cmd_decode
    import ctl_irq_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output cmd_kind_e       kind
);
    always_comb begin
        unique case (op)
            OP_NOP:    kind = CK_NOP;
            OP_FLUSH:  kind = CK_FLUSH;
            OP_SRST:   kind = CK_SRST;
            OP_BRST:   kind = CK_BRST;
            OP_MSGACC: kind = CK_MSGACC;
            OP_PAD:    kind = CK_PAD;
            OP_ENSEL:  kind = CK_ENSEL;
            OP_DISSEL: kind = CK_DISSEL;
            OP_XFER, OP_SEL, OP_SELATN: kind = CK_LAUNCH;
            default:   kind = CK_NONE;
        endcase
    end
endmodule

// File: rtl/ctl_seq_fsm.sv
module ctl_seq_fsm
    import ctl_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_clr,
    input  logic            req,
    input  logic [OP_W-1:0] req_op,
    input  logic            req_dma,
    input  logic            dma_en,
    input  logic            op_done,
    output logic            launch,
    output logic [OP_W-1:0] launch_op,
    output logic            launch_dma,
    output logic            done_ok
);
    seq_state_e      state_q, state_d;
    logic [OP_W-1:0] pend_op_q;
    logic            pend_dma_q;
    logic            req_park, go_now, go_late;

    assign req_park = req && req_dma && !dma_en;
    assign go_now   = !soft_clr && req && !req_park;
    assign go_late  = !soft_clr && !req && (state_q == ST_WAIT_DMA) && dma_en;
    assign done_ok  = !soft_clr && !req && (state_q == ST_BUSY) && op_done;

    always_comb begin
        state_d = state_q;
        if (soft_clr) begin
            state_d = ST_IDLE;
        end else if (req) begin
            state_d = req_park ? ST_WAIT_DMA : ST_BUSY;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_WAIT_DMA: state_d = dma_en ? ST_BUSY : ST_WAIT_DMA;
                ST_BUSY:     state_d = op_done ? ST_IDLE : ST_BUSY;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_op_q  <= '0;
            pend_dma_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req) begin
                pend_op_q  <= req_op;
                pend_dma_q <= req_dma;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch     <= 1'b0;
            launch_op  <= '0;
            launch_dma <= 1'b0;
        end else begin
            launch <= go_now || go_late;
            if (go_now) begin
                launch_op  <= req_op;
                launch_dma <= req_dma;
            end else if (go_late) begin
                launch_op  <= pend_op_q;
                launch_dma <= pend_dma_q;
            end
        end
    end
endmodule

// File: rtl/ctl_irq_core.sv
module ctl_irq_core
    import ctl_irq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              dma_en,
    input  logic              op_done,
    input  logic [REG_W-1:0]  done_flags,
    output logic              irq,
    output logic              launch,
    output logic [OP_W-1:0]   launch_op,
    output logic              launch_dma
);
    logic [REG_W-1:0] cmd_q, status_q, reason_q, step_q, flags_q, cfg1_q;
    cmd_kind_e        kind;
    logic             cmd_wr, cfg_wr, ack_rd, soft_clr, done_ok;

    assign cmd_wr   = wr_en && (addr == ADDR_W'(A_CMD));
    assign cfg_wr   = wr_en && (addr == ADDR_W'(A_CFG1));
    assign ack_rd   = rd_en && (addr == ADDR_W'(A_REASON));
    assign soft_clr = cmd_wr && (kind == CK_SRST);

    ctl_cmd_decode i_dec (
        .op   (wr_data[OP_W-1:0]),
        .kind (kind)
    );

    ctl_seq_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_clr   (soft_clr),
        .req        (cmd_wr && (kind == CK_LAUNCH)),
        .req_op     (wr_data[OP_W-1:0]),
        .req_dma    (wr_data[REG_W-1]),
        .dma_en     (dma_en),
        .op_done    (op_done),
        .launch     (launch),
        .launch_op  (launch_op),
        .launch_dma (launch_dma),
        .done_ok    (done_ok)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            cmd_q    <= '0;
            status_q <= '0;
            reason_q <= '0;
            step_q   <= '0;
            flags_q  <= '0;
            cfg1_q   <= CFG1_INIT;
        end else begin
            if (ack_rd) begin
                reason_q         <= '0;
                status_q[ST_TC]  <= 1'b0;
                status_q[ST_INT] <= 1'b0;
                step_q           <= STEP_DONE;
            end
            if (done_ok) begin
                status_q <= '0;
                status_q[ST_TC]  <= 1'b1;
                status_q[ST_INT] <= 1'b1;
                reason_q <= RS_BUS | RS_FC;
                step_q   <= STEP_DONE;
                flags_q  <= done_flags;
            end
            if (cmd_wr && kind != CK_NONE) begin
                cmd_q <= wr_data;
                unique case (kind)
                    CK_FLUSH: begin
                        reason_q <= RS_FC;
                        step_q   <= '0;
                        flags_q  <= '0;
                    end
                    CK_BRST: begin
                        reason_q <= RS_RESET;
                        if (!cfg1_q[CFG_NOREP]) status_q[ST_INT] <= 1'b1;
                    end
                    CK_MSGACC: begin
                        reason_q         <= RS_DISC;
                        step_q           <= '0;
                        flags_q          <= '0;
                        status_q[ST_INT] <= 1'b1;
                    end
                    CK_PAD: begin
                        status_q[ST_TC] <= 1'b1;
                        reason_q        <= RS_FC;
                        step_q          <= '0;
                    end
                    CK_ENSEL: reason_q <= '0;
                    CK_DISSEL: begin
                        reason_q         <= '0;
                        status_q[ST_INT] <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (cfg_wr) cfg1_q <= wr_data;
        end
    end

    assign irq = status_q[ST_INT];

    always_comb begin
        unique case (int'(addr))
            A_CMD:    rd_data = cmd_q;
            A_STAT:   rd_data = status_q;
            A_REASON: rd_data = reason_q;
            A_STEP:   rd_data = step_q;
            A_FLAGS:  rd_data = flags_q;
            A_CFG1:   rd_data = cfg1_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ctl_irq_core_chk.sv
module ctl_irq_core_chk
    import ctl_irq_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  cfg1_q,
    input logic              dma_en,
    input logic              op_done,
    input logic              irq,
    input logic              launch,
    input logic              launch_dma
);
    logic cmd_wr;
    assign cmd_wr = wr_en && (addr == ADDR_W'(A_CMD));

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(wr_en) || $past(op_done))); // R1

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(A_REASON) && !wr_en && !op_done) |=> !irq); // R2

    AST_BUSRST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wr_data[OP_W-1:0] == OP_BRST && cfg1_q[CFG_NOREP] && !irq && !op_done && !rd_en) |=> !irq); // R3

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wr_data[OP_W-1:0] == OP_FLUSH && !irq && !op_done && !rd_en) |=> !irq); // R4

    AST_DMA_LAUNCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && launch_dma) |-> $past(dma_en)); // R8

    AST_NO_SPONTANEOUS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_en && !cmd_wr) |=> !launch); // R8
endmodule

bind ctl_irq_core ctl_irq_core_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .cfg1_q     (cfg1_q),
    .dma_en     (dma_en),
    .op_done    (op_done),
    .irq        (irq),
    .launch     (launch),
    .launch_dma (launch_dma)
);

// File: tb/test_ctl_irq_core.sv
module test_ctl_irq_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wr_data = '0, rd_data, done_flags = '0;
    logic       dma_en = 1'b1, op_done = 1'b0;
    logic       irq, launch, launch_dma;
    logic [6:0] launch_op;
    int         n_run = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #4 clk = ~clk;

    ctl_irq_core i_ctl_irq_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .dma_en(dma_en), .op_done(op_done),
        .done_flags(done_flags), .irq(irq), .launch(launch),
        .launch_op(launch_op), .launch_dma(launch_dma)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        addr = a; #1; v = rd_data;
    endtask

    task automatic ack(output logic [7:0] v);
        @(negedge clk); addr = 3'd2; rd_en = 1'b1; #1; v = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    function automatic bit is_launch(input logic [6:0] op);
        return op == 7'h10 || op == 7'h41 || op == 7'h42;
    endfunction

    function automatic bit is_known(input logic [6:0] op);
        return is_launch(op) || op inside {7'h00, 7'h01, 7'h02, 7'h03, 7'h12, 7'h18, 7'h44, 7'h45};
    endfunction

    function automatic logic [7:0] exp_reason(input logic [6:0] op);
        case (op)
            7'h01, 7'h18: return 8'h08;
            7'h03:        return 8'h80;
            7'h12:        return 8'h20;
            default:      return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_status(input logic [6:0] op);
        case (op)
            7'h03, 7'h12, 7'h45: return 8'h80;
            7'h18:               return 8'h10;
            default:             return 8'h00;
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got %h expected %h", 8'h0, 8'h1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        do_reset();
        peek(3'd5, v); check("R10 cfg reset", v, 8'h07);
        peek(3'd1, v); check("R10 status reset", v, 8'h00);
        check("R10 irq reset", {7'd0, irq}, 8'h00);

        // R9: completion strobe outside the busy state does nothing
        @(negedge clk); done_flags = 8'hA5; op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        peek(3'd4, v); check("R9 idle done flags", v, 8'h00);
        peek(3'd2, v); check("R9 idle done reason", v, 8'h00);

        // Sweep: every opcode, DMA flag, dma_en level (R4..R8, R11)
        for (int den = 0; den < 2; den++) begin
            for (int dm = 0; dm < 2; dm++) begin
                for (int op = 0; op < 128; op++) begin
                    logic [6:0] o;
                    logic [7:0] ec;
                    bit el;
                    o = 7'(op);
                    do_reset();
                    dma_en = den[0];
                    wr(3'd0, {dm[0], o});
                    el = is_launch(o) && !(dm == 1 && den == 0);
                    check("R8 launch sweep", {7'd0, launch}, {7'd0, el});
                    if (el) check("R8 launch_op sweep", {1'b0, launch_op}, {1'b0, o});
                    ec = (is_known(o) && o != 7'h02) ? {dm[0], o} : 8'h00;
                    peek(3'd0, v); check("R11 command readback", v, ec);
                    peek(3'd1, v); check("R6 R7 status sweep", v, exp_status(o));
                    check("R1 irq mirrors INT", {7'd0, irq}, {7'd0, exp_status(o)[7]});
                    ack(v); check("R2 R3 R4 R5 reason sweep", v, exp_reason(o));
                    peek(3'd1, v); check("R2 status after ack", v, 8'h00);
                    peek(3'd3, v); check("R2 step after ack", v, 8'h04);
                    check("R2 irq after ack", {7'd0, irq}, 8'h00);
                end
            end
        end

        // R3: masked bus reset
        do_reset();
        dma_en = 1'b1;
        wr(3'd5, 8'h47);
        peek(3'd5, v); check("R1 cfg write", v, 8'h47);
        wr(3'd0, 8'h03);
        check("R3 masked irq", {7'd0, irq}, 8'h00);
        peek(3'd2, v); check("R3 masked reason", v, 8'h80);

        // R8: parked DMA selection
        dma_en = 1'b0;
        wr(3'd0, 8'hC1);
        check("R8 parked no launch", {7'd0, launch}, 8'h00);
        repeat (3) begin
            @(negedge clk);
            check("R8 parked hold", {7'd0, launch}, 8'h00);
        end
        dma_en = 1'b1;
        @(negedge clk);
        check("R8 deferred launch", {7'd0, launch}, 8'h01);
        check("R8 deferred op", {1'b0, launch_op}, 8'h41);
        check("R8 deferred dma", {7'd0, launch_dma}, 8'h01);
        @(negedge clk);
        check("R8 single pulse", {7'd0, launch}, 8'h00);

        // R9: completion in busy state
        done_flags = 8'h5A; op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        peek(3'd1, v); check("R9 status", v, 8'h90);
        peek(3'd2, v); check("R9 reason", v, 8'h18);
        peek(3'd3, v); check("R9 step", v, 8'h04);
        peek(3'd4, v); check("R9 flags", v, 8'h5A);
        check("R9 irq", {7'd0, irq}, 8'h01);

        // R4: flush keeps a pending interrupt
        wr(3'd0, 8'h01);
        check("R4 irq kept", {7'd0, irq}, 8'h01);
        peek(3'd4, v); check("R4 flags zero", v, 8'h00);
        peek(3'd3, v); check("R4 step zero", v, 8'h00);
        ack(v); check("R2 old reason", v, 8'h08);
        check("R2 irq dropped", {7'd0, irq}, 8'h00);

        // R9: second completion while idle is ignored
        done_flags = 8'h33; op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        peek(3'd4, v); check("R9 ignored after done", v, 8'h00);

        // R10: soft reset restores config
        wr(3'd5, 8'h00);
        wr(3'd0, 8'h02);
        peek(3'd5, v); check("R10 soft reset cfg", v, 8'h07);
        peek(3'd3, v); check("R10 soft reset step", v, 8'h00);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule